// File: doc/BRIEF.md
# Sixteen-Input Population Counter

This block reports how many of its sixteen single-bit inputs are high, as a five-bit unsigned number from 0 to 16. It has no clock, no reset and no storage. Every input change settles to the new count within one combinational evaluation, so the block can sit between two register stages of a wider datapath, or be instantiated more than once side by side.

The count is reduced through a fixed schedule of six compressor layers. Each full adder (3:2) and half adder (2:2) is written out from XOR, AND and OR gates. No arithmetic operator and no carry-propagate adder appear anywhere. The longest path through the tree is about six XOR delays.

Top module: `popcnt16_csa`

## Requirements
- R1: For every one of the 65536 input patterns, `count` equals the number of bits of `din` that are 1, exactly.
- R2: When `din` is all zeros, `count` is 0.
- R3: When `din` is all ones, `count` is 16, encoded as bit 4 set and bits 3 to 0 clear.
- R4: `count[4]` is 1 only when all sixteen inputs are 1, and whenever `count[4]` is 1, `count[3:0]` is 0.
- R5: Every input has weight one. A single set bit at any of the sixteen positions gives a count of 1.
- R6: The block holds no state. A new input value gives the correct count at once, with no dependence on earlier inputs, including back-to-back swings between extreme patterns.
- R7: `count` never exceeds 16.
- R8: `count[0]` equals the XOR parity of all sixteen inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 16 | Bits to be counted, each of weight one |
| count | output | 5 | Unsigned number of set bits in `din`, 0 to 16 |

## Verification
The rarest situation is the single pattern with all inputs high. It is the only one that drives the top half adder's carry, and so the only one that shows whether the final layer sets bit 4 and clears the lower bits. An exhaustive sweep over all 65536 values reaches it only once, at the very end. The stimulus therefore also places the all-ones word up front, and toggles it against all-zeros and one-hot words on consecutive cycles, so that the upper weights are exercised with no settling time left over from an earlier input.

// File: rtl/popcnt16_csa.sv
module popcnt16_csa (
  input  logic [15:0] din,
  output logic [4:0]  count
);

  function automatic logic [1:0] fa(input logic a, input logic b, input logic c);
    logic s, k;
    s = a ^ b ^ c;
    k = (a & b) | (a & c) | (b & c);
    return {k, s};
  endfunction

  function automatic logic [1:0] ha(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction

  // Layer 1: five full adders on fifteen unit-weight bits, din[15] passes
  logic [1:0] l1 [5];
  for (genvar g = 0; g < 5; g++) begin : g_l1
    assign l1[g] = fa(din[3*g], din[3*g+1], din[3*g+2]);
  end
  // unit weight: l1[0..4][0], din[15]; weight two: l1[0..4][1]

  // Layer 2: two full adders on unit weight, one half adder on weight two
  logic [1:0] l2a, l2b, l2h;
  assign l2a = fa(l1[0][0], l1[1][0], l1[2][0]);
  assign l2b = fa(l1[3][0], l1[4][0], din[15]);
  assign l2h = ha(l1[3][1], l1[4][1]);
  // unit: l2a[0], l2b[0]
  // two : l2a[1], l2b[1], l1[0][1], l1[1][1], l1[2][1], l2h[0]
  // four: l2h[1]

  // Layer 3: half adder on unit weight, two full adders on weight two
  logic [1:0] l3h, l3a, l3b;
  assign l3h = ha(l2a[0], l2b[0]);
  assign l3a = fa(l2a[1], l2b[1], l1[0][1]);
  assign l3b = fa(l1[1][1], l1[2][1], l2h[0]);
  // unit: l3h[0]
  // two : l3h[1], l3a[0], l3b[0]
  // four: l2h[1], l3a[1], l3b[1]

  // Layer 4: full adder on weight two, full adder on weight four
  logic [1:0] l4a, l4b;
  assign l4a = fa(l3h[1], l3a[0], l3b[0]);
  assign l4b = fa(l2h[1], l3a[1], l3b[1]);
  // two  : l4a[0]
  // four : l4a[1], l4b[0]
  // eight: l4b[1]

  // Layer 5: half adder on weight four
  logic [1:0] l5;
  assign l5 = ha(l4a[1], l4b[0]);
  // four : l5[0]
  // eight: l5[1], l4b[1]

  // Layer 6: half adder resolves weight eight into bits 3 and 4
  logic [1:0] l6;
  assign l6 = ha(l5[1], l4b[1]);

  assign count = {l6[1], l6[0], l5[0], l4a[0], l3h[0]};

  always_comb begin
    AST_ZERO_IN: assert (din != 16'h0000 || count == 5'd0) else $error("zero input gave nonzero count");  // R2
    AST_FULL_IN: assert (din != 16'hFFFF || count == 5'b10000) else $error("full input miscounted");      // R3
    AST_TOP_BIT_CLEAN: assert (!count[4] || (count[3:0] == 4'd0 && din == 16'hFFFF)) else $error("bit 4 misuse"); // R4
    AST_NO_OVERFLOW: assert (count <= 5'd16) else $error("count above sixteen");                          // R7
    AST_PARITY: assert (count[0] == ^din) else $error("bit 0 differs from parity");                        // R8
  end

endmodule

// File: tb/popcnt16_csa_test.sv
module popcnt16_csa_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] din = 16'h0000;
  logic [4:0]  count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] q_pat [$];
  logic [4:0]  q_exp [$];
  string       q_tag [$];

  popcnt16_csa uut (.din(din), .count(count));

  always #10 clk = ~clk;

  function automatic logic [4:0] ref_count(input logic [15:0] v);
    logic [4:0] n = 5'd0;
    for (int i = 0; i < 16; i++) if (v[i]) n = n + 5'd1;
    return n;
  endfunction

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp, input logic [15:0] pat);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s din=%h actual=%0d expected=%0d", tag, pat, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] v, input string tag);
    @(posedge clk);
    din <= v;
    q_pat.push_back(v);
    q_exp.push_back(ref_count(v));
    q_tag.push_back(tag);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops one expected item per cycle, samples on the falling edge
  always @(negedge clk) begin
    if (!rst && q_pat.size() > 0) begin
      logic [15:0] p;
      logic [4:0]  e;
      string       t;
      p = q_pat.pop_front();
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      check(t, count, e, p);
      check("R8", {4'd0, count[0]}, {4'd0, ^p}, p);
      check("R7", (count <= 5'd16) ? 5'd1 : 5'd0, 5'd1, p);
      if (p == 16'hFFFF) check("R4", {1'b0, count[3:0]}, 5'd0, p);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R2", count, 5'd0, din);  // value seen during reset
    rst = 1'b0;

    drive(16'h0000, "R2");
    drive(16'hFFFF, "R3");
    for (int i = 0; i < 16; i++) drive(16'h0001 << i, "R5");
    drive(16'hFFFF, "R6");
    drive(16'h0000, "R6");
    drive(16'hFFFF, "R6");
    drive(16'h8000, "R6");
    drive(16'h7FFF, "R6");
    drive(16'hAAAA, "R6");
    drive(16'h5555, "R6");
    drive(16'hFFFF, "R4");
    for (int v = 0; v < 65536; v++) drive(v[15:0], "R1");

    while (q_pat.size() > 0) @(posedge clk);
    @(posedge clk);
    finish_run();
  end

endmodule